// File: doc/BRIEF.md
# ADC Conversion Trigger Selector

This block decides when an ADC conversion sequencer may start. It issues a single-cycle start pulse, `start_o`, whenever a software start write arrives or the hardware source picked by a 3-bit mode field fires. The hardware sources are edges on an external trigger pin (rising, falling or both), a rising pen-contact flag, an automatic retrigger at the end of each sequence, and a periodic tick from a reloading down-counter.

The software start is never masked by the mode: it works in every mode, including the hardware ones. The block tracks whether a sequence is running. It sets an internal busy flag on each start pulse and clears it when the sequencer returns `seq_done_i`. Any trigger that arrives while busy is dropped, unless `seq_done_i` is high in the same cycle. Because of this, continuous mode needs only one software start to begin an endless run of sequences.

Top module: `adc_trig_sel`

## Requirements
- R1: While `rst_ni` is low, and in the first cycles after it is released with no stimulus, `start_o` is 0.
- R2: A one-cycle `start_wr_i` sampled on a clock edge while idle gives `start_o` = 1 for exactly the following cycle, then 0.
- R3: In mode 1, a low-to-high transition on `ext_trig_i` gives exactly one start pulse, about three cycles later because of the two-flop synchronizer. A high-to-low transition gives none.
- R4: In mode 2, a high-to-low transition on `ext_trig_i` gives exactly one start pulse. A low-to-high transition gives none.
- R5: In mode 3, both directions of transition on `ext_trig_i` give one start pulse each.
- R6: In mode 4, a 0-to-1 change of `pen_det_i` gives one start pulse only when `pen_en_i` = 1. A steady high level does not retrigger.
- R7: In mode 6, each `seq_done_i` pulse gives a start pulse in the next cycle. In other modes, `seq_done_i` starts nothing.
- R8: In mode 5, with `seq_done_i` held high, start pulses repeat every `period_i`+1 cycles. The down-counter reloads from `period_i` each time it reaches zero and while the mode is not 5.
- R9: A software start produces a pulse in every mode, including modes 1, 5 and 6.
- R10: From one start pulse until `seq_done_i` is seen, every trigger (software or hardware) is dropped and `start_o` stays 0.
- R11: In mode 0 and in mode 7, no hardware event (pin edge, pen flag, sequence done) gives a start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_trig_i | input | 1 | External trigger pin, asynchronous |
| pen_det_i | input | 1 | Pen contact flag, synchronous level |
| pen_en_i | input | 1 | Pen detection enable |
| seq_done_i | input | 1 | Sequencer finished pulse |
| mode_i | input | 3 | Trigger mode: 0 none, 1 rise, 2 fall, 3 any edge, 4 pen, 5 periodic, 6 continuous, 7 none |
| period_i | input | PER_W | Periodic reload value |
| start_wr_i | input | 1 | Software start write strobe |
| start_o | output | 1 | One-cycle sequence start pulse |

## Verification
The assertions check, on every cycle, the properties that depend only on the last edge:
- a start pulse never appears while busy without a done;
- an accepted software write or a continuous-mode done always produces a pulse;
- mode 0 emits nothing hardware-driven;
- the period counter either reloads or decrements by one.

Only the bench scenarios can show the multi-cycle effects:
- the synchronizer latency and edge polarity selection;
- pen enable gating and level insensitivity;
- the actual pulse spacing for a given period.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam int MODE_W = 3;
  typedef enum logic [MODE_W-1:0] {
    TM_NONE   = 3'd0,
    TM_RISE   = 3'd1,
    TM_FALL   = 3'd2,
    TM_ANY    = 3'd3,
    TM_PEN    = 3'd4,
    TM_PERIOD = 3'd5,
    TM_CONT   = 3'd6,
    TM_RSVD   = 3'd7
  } trig_mode_e;
endpackage

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= pin_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[s] <= 1'b0;
      else         sync_q[s] <= sync_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign rise_o =  sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] &  prev_q;
endmodule

// File: rtl/adc_trig_period.sv
module adc_trig_period #(
  parameter int PER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PER_W-1:0] period_i,
  output logic             tick_o
);
  logic [PER_W-1:0] cnt_q;
  logic             zero;

  assign zero   = (cnt_q == '0);
  assign tick_o = en_i & zero;

  // reload while idle so the first tick comes period_i cycles after enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i || zero) cnt_q <= period_i;
    else                    cnt_q <= cnt_q - PER_W'(1);
  end

  AST_PER_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |=> (cnt_q == $past(period_i)));  // R8
  AST_PER_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - PER_W'(1)));  // R8
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_trig_pkg::*;
#(
  parameter int PER_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_trig_i,
  input  logic              pen_det_i,
  input  logic              pen_en_i,
  input  logic              seq_done_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic              start_wr_i,
  output logic              start_o
);
  trig_mode_e mode;
  logic ext_rise, ext_fall, per_tick, pen_evt;
  logic pen_prev_q, busy_q, start_q;
  logic hw_trig, accept, start_d;

  assign mode = trig_mode_e'(mode_i);

  adc_trig_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_trig_i),
    .rise_o (ext_rise),
    .fall_o (ext_fall)
  );

  adc_trig_period #(.PER_W(PER_W)) u_per (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (mode == TM_PERIOD),
    .period_i (period_i),
    .tick_o   (per_tick)
  );

  assign pen_evt = pen_en_i & pen_det_i & ~pen_prev_q;

  always_comb begin
    unique case (mode)
      TM_RISE:   hw_trig = ext_rise;
      TM_FALL:   hw_trig = ext_fall;
      TM_ANY:    hw_trig = ext_rise | ext_fall;
      TM_PEN:    hw_trig = pen_evt;
      TM_PERIOD: hw_trig = per_tick;
      TM_CONT:   hw_trig = seq_done_i;
      default:   hw_trig = 1'b0;
    endcase
  end

  // a done in the same cycle frees the sequencer for a new start
  assign accept  = ~busy_q | seq_done_i;
  assign start_d = (hw_trig | start_wr_i) & accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pen_prev_q <= 1'b0;
      busy_q     <= 1'b0;
      start_q    <= 1'b0;
    end else begin
      pen_prev_q <= pen_det_i;
      busy_q     <= (busy_q & ~seq_done_i) | start_d;
      start_q    <= start_d;
    end
  end

  assign start_o = start_q;

  AST_BUSY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !seq_done_i) |=> !start_o);  // R10
  AST_SW_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_wr_i && !busy_q) |=> start_o);  // R9
  AST_CONT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd6 && seq_done_i) |=> start_o);  // R7
  AST_NONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd0 && !start_wr_i) |=> !start_o);  // R11
  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> !start_o);  // R1
endmodule

// File: tb/sim_adc_trig_sel.sv
`timescale 1ns/1ps
module sim_adc_trig_sel;
  localparam int PER_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext = 1'b0, pen = 1'b0, pen_en = 1'b0, done = 1'b0, swr = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [PER_W-1:0] period = '0;
  logic start;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  adc_trig_sel #(.PER_W(PER_W), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ext_trig_i(ext), .pen_det_i(pen),
    .pen_en_i(pen_en), .seq_done_i(done), .mode_i(mode),
    .period_i(period), .start_wr_i(swr), .start_o(start)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_win(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (start) c++;
    end
  endtask

  task automatic done_pulse();
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic sw_pulse(output int seen);
    swr = 1'b1;
    @(negedge clk);
    swr = 1'b0;
    seen = int'(start);
  endtask

  task automatic idle();
    mode = 3'd0;
    swr = 1'b0;
    done_pulse();
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    int c;
    repeat (3) @(negedge clk);
    check("R1 during reset", int'(start), 0);
    rst_n = 1'b1;
    count_win(4, c);
    check("R1 after reset", c, 0);
  endtask

  task automatic t_sw();
    int s;
    idle();
    sw_pulse(s);
    check("R2 pulse next cycle", s, 1);
    @(negedge clk);
    check("R2 single cycle", int'(start), 0);
    idle();
  endtask

  task automatic t_rise();
    int c;
    mode = 3'd1;
    ext = 1'b1;
    count_win(6, c);
    check("R3 rising edge", c, 1);
    done_pulse();
    ext = 1'b0;
    count_win(6, c);
    check("R3 falling ignored", c, 0);
    idle();
  endtask

  task automatic t_fall();
    int c;
    mode = 3'd2;
    ext = 1'b1;
    count_win(6, c);
    check("R4 rising ignored", c, 0);
    ext = 1'b0;
    count_win(6, c);
    check("R4 falling edge", c, 1);
    idle();
  endtask

  task automatic t_any();
    int c;
    mode = 3'd3;
    ext = 1'b1;
    count_win(6, c);
    check("R5 rise", c, 1);
    done_pulse();
    ext = 1'b0;
    count_win(6, c);
    check("R5 fall", c, 1);
    idle();
  endtask

  task automatic t_none();
    int c;
    for (int m = 0; m < 8; m += 7) begin
      mode = 3'(m);
      pen_en = 1'b1;
      ext = 1'b1; pen = 1'b1;
      count_win(5, c);
      check("R11 edges and pen ignored", c, 0);
      ext = 1'b0; pen = 1'b0;
      done = 1'b1;
      count_win(5, c);
      done = 1'b0;
      check("R11 done ignored", c, 0);
    end
    pen_en = 1'b0;
    idle();
  endtask

  task automatic t_pen();
    int c;
    mode = 3'd4;
    pen_en = 1'b0;
    pen = 1'b1;
    count_win(4, c);
    check("R6 pen disabled", c, 0);
    pen = 1'b0;
    @(negedge clk);
    pen_en = 1'b1;
    pen = 1'b1;
    count_win(4, c);
    check("R6 pen event", c, 1);
    done_pulse();
    count_win(4, c);
    check("R6 level no retrigger", c, 0);
    pen = 1'b0;
    pen_en = 1'b0;
    idle();
  endtask

  task automatic t_cont();
    int s, c;
    mode = 3'd6;
    sw_pulse(s);
    check("R7 initial sw start", s, 1);
    for (int k = 0; k < 3; k++) begin
      done_pulse();
      check("R7 restart after done", int'(start), 1);
      @(negedge clk);
      check("R7 one cycle", int'(start), 0);
    end
    mode = 3'd0;
    done_pulse();
    count_win(4, c);
    check("R7 no restart outside mode 6", c, 0);
    idle();
  endtask

  task automatic t_per();
    int c, last, gap_bad;
    period = 16'd3;
    mode = 3'd0;
    @(negedge clk);
    done = 1'b1;
    mode = 3'd5;
    c = 0; last = -1; gap_bad = 0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (start) begin
        if (last >= 0 && i - last != 4) gap_bad++;
        last = i;
        c++;
      end
    end
    check("R8 pulses in 20 cycles, period 3", c, 5);
    check("R8 spacing period+1", gap_bad, 0);
    mode = 3'd0;
    period = '0;
    @(negedge clk);
    mode = 3'd5;
    count_win(10, c);
    check("R8 period 0 every cycle", c, 10);
    mode = 3'd0;
    @(negedge clk);
    done = 1'b0;
    idle();
  endtask

  task automatic t_sw_hw();
    int s;
    mode = 3'd1;
    sw_pulse(s);
    check("R9 sw in rise mode", s, 1);
    done_pulse();
    period = 16'd1000;
    mode = 3'd0;
    @(negedge clk);
    mode = 3'd5;
    sw_pulse(s);
    check("R9 sw in periodic mode", s, 1);
    done_pulse();
    mode = 3'd6;
    sw_pulse(s);
    check("R9 sw in continuous mode", s, 1);
    mode = 3'd0;
    idle();
  endtask

  task automatic t_busy();
    int s, c;
    sw_pulse(s);
    check("R10 first start", s, 1);
    sw_pulse(s);
    check("R10 sw dropped while busy", s, 0);
    mode = 3'd1;
    ext = 1'b1;
    count_win(6, c);
    check("R10 edge dropped while busy", c, 0);
    ext = 1'b0;
    mode = 3'd0;
    done_pulse();
    sw_pulse(s);
    check("R10 start after done", s, 1);
    idle();
  endtask

  initial begin
    t_reset();
    t_sw();
    t_rise();
    t_fall();
    t_any();
    t_none();
    t_pen();
    t_cont();
    t_per();
    t_sw_hw();
    t_busy();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule